// File: doc/BRIEF.md
# Parallel Printer Port Register Controller

This block is the host-facing register file of a parallel printer port. It also contains a small model of the printer's handshake. Software reaches three byte-wide registers through a single-cycle access port: a data register, a status register and a control register. Control writes are what drive the printer model. Clearing the init line resets the printer status. Raising strobe while the printer is selected clears busy, and a raising edge of strobe emits the output byte. Dropping strobe while interrupts are enabled raises an interrupt request.

Each status read returns the current status and then steps the printer model. When the printer is idle and strobe is low, successive reads toggle the acknowledge line and re-assert busy, which lets a polling driver complete its handshake. An input byte latch is loaded from outside the block, and the direction bit in the control register decides which latch a data read returns. The transmitted byte leaves on a one-cycle valid/byte pair. The interrupt is a level output.

Top module: `prn_port_regs`

## Requirements
- R1: Only address bits [2:0] are decoded, and higher bits are ignored. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF.
- R2: A control write stores the written value with bits 7 and 6 forced to 1. A control read returns the stored value.
- R3: A control write with bit 2 (init) equal to 0 sets the status to 0xD8, which is busy bit 7, ack bit 6, online bit 4 and error bit 3.
- R4: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7. If the previously stored strobe was 0, txValid is high for exactly the following cycle, and txByte then carries the output latch.
- R5: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets interrupt pending when the previously stored control had bit 4 (interrupt enable) set.
- R6: A data write loads the output latch, and inLoad loads the input latch from inByte. A data read returns the input latch when control bit 5 is 1, and the output latch when it is 0.
- R7: A status read returns the current status and clears interrupt pending.
- R8: After a status read, if status bit 7 was 0 and control bit 0 was 0, the block acts on ack. If status bit 6 was set, it is cleared. Otherwise bits 6 and 7 are both set. In any other case the status is unchanged.
- R9: After reset both latches are 0xFF, the status is 0xD9, the control is 0xCC and the interrupt is low.
- R10: irqOut is the interrupt pending level. It changes only in the cycle after a write or a read.
- R11: When rdEn and wrEn are both high, only the write takes effect, and no status-read side effect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address; the low 3 bits are decoded |
| rdEn | input | 1 | Read access this cycle |
| wrEn | input | 1 | Write access this cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data |
| inByte | input | 8 | Byte from the printer side |
| inLoad | input | 1 | Load inByte into the input latch |
| txValid | output | 1 | One-cycle pulse: a byte is sent |
| txByte | output | 8 | Sent byte, valid with txValid |
| irqOut | output | 1 | Level interrupt request |

## Verification
The embedded assertions check on every cycle the following properties:
- how a control write is stored;
- the status produced by init-low;
- that a send pulse lasts exactly one cycle and carries the output latch;
- that a status read clears the pending flag;
- that the interrupt holds steady when there is no access;
- that a combined read-and-write leaves the status alone.

The handshake orderings only show up through the bench's scenarios, because they depend on earlier control history. These include the ack/busy toggling over consecutive status reads, the suppression of a second send when strobe stays high, and the interrupt that needs interrupt enable already stored. The bench's scenarios are also needed for read-mux selection by the direction bit, for address aliasing and for the reset values.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int DEC_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [DEC_W-1:0] OFS_DATA = 3'd0;
  localparam logic [DEC_W-1:0] OFS_STAT = 3'd1;
  localparam logic [DEC_W-1:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STROBE = 0;
  localparam int C_INIT   = 2;
  localparam int C_SELECT = 3;
  localparam int C_IRQEN  = 4;
  localparam int C_DIR    = 5;
  // status bit positions
  localparam int S_ACK    = 6;
  localparam int S_BUSY   = 7;

  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] BYTE_ONES  = 8'hFF;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic loadOut;
    logic loadCtrl;
    logic statInit;
    logic clrBusy;
    logic sendByte;
    logic setPend;
    logic clrPend;
    logic clrAck;
    logic setAckBusy;
  } strobe_t;
endpackage

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl
  import prn_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] ctrlReg,
  input  logic [BYTE_W-1:0] statReg,
  output strobe_t           st,
  output rd_sel_e           rdSel
);
  logic [DEC_W-1:0]  offs;
  logic              isData, isStat, isCtrl;
  logic              doRd, hsWrite, stepOk;
  logic [BYTE_W-1:0] newCtrl;

  assign offs   = addr[DEC_W-1:0];
  assign isData = (offs == OFS_DATA);
  assign isStat = (offs == OFS_STAT);
  assign isCtrl = (offs == OFS_CTRL);

  // a write wins over a read issued in the same cycle
  assign doRd    = rdEn & ~wrEn;
  assign newCtrl = wrData | CTRL_FORCE;
  assign hsWrite = wrEn & isCtrl & newCtrl[C_INIT] & newCtrl[C_SELECT];
  assign stepOk  = ~statReg[S_BUSY] & ~ctrlReg[C_STROBE];

  always_comb begin
    st            = '0;
    st.loadOut    = wrEn & isData;
    st.loadCtrl   = wrEn & isCtrl;
    st.statInit   = wrEn & isCtrl & ~newCtrl[C_INIT];
    st.clrBusy    = hsWrite & newCtrl[C_STROBE];
    st.sendByte   = hsWrite & newCtrl[C_STROBE] & ~ctrlReg[C_STROBE];
    st.setPend    = hsWrite & ~newCtrl[C_STROBE] & ctrlReg[C_IRQEN];
    st.clrPend    = doRd & isStat;
    st.clrAck     = doRd & isStat & stepOk & statReg[S_ACK];
    st.setAckBusy = doRd & isStat & stepOk & ~statReg[S_ACK];
  end

  always_comb begin
    if (isData)      rdSel = SEL_DATA;
    else if (isStat) rdSel = SEL_STAT;
    else if (isCtrl) rdSel = SEL_CTRL;
    else             rdSel = SEL_NONE;
  end

  // R8: the ack step never happens while the printer is busy
  p_step_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st.clrAck || st.setAckBusy) |-> (!statReg[S_BUSY] && !ctrlReg[C_STROBE]));
endmodule

// File: rtl/prn_port_dp.sv
module prn_port_dp
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  rd_sel_e           rdSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inLoad,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [BYTE_W-1:0] statReg,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              irqPend
);
  logic [BYTE_W-1:0] outLatch;
  logic [BYTE_W-1:0] inLatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outLatch <= BYTE_ONES;
      inLatch  <= BYTE_ONES;
      ctrlReg  <= CTRL_RST;
    end else begin
      if (st.loadOut)  outLatch <= wrData;
      if (inLoad)      inLatch  <= inByte;
      if (st.loadCtrl) ctrlReg  <= wrData | CTRL_FORCE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statReg <= STAT_RST;
    end else if (st.statInit) begin
      statReg <= STAT_INIT;
    end else if (st.clrBusy) begin
      statReg[S_BUSY] <= 1'b0;
    end else if (st.clrAck) begin
      statReg[S_ACK] <= 1'b0;
    end else if (st.setAckBusy) begin
      statReg[S_ACK]  <= 1'b1;
      statReg[S_BUSY] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqPend <= 1'b0;
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      if (st.setPend)      irqPend <= 1'b1;
      else if (st.clrPend) irqPend <= 1'b0;
      txValid <= st.sendByte;
      if (st.sendByte) txByte <= outLatch;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_DATA: rdData = ctrlReg[C_DIR] ? inLatch : outLatch;
      SEL_STAT: rdData = statReg;
      SEL_CTRL: rdData = ctrlReg;
      default:  rdData = BYTE_ONES;
    endcase
  end

  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadCtrl |=> ctrlReg == ($past(wrData) | CTRL_FORCE));
  p_init_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st.statInit |=> statReg == STAT_INIT);
  p_tx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |=> !txValid);
  p_tx_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st.sendByte |=> (txValid && txByte == $past(outLatch)));
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st.clrPend |=> !irqPend);
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        inByte,
  input  logic              inLoad,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              irqOut
);
  strobe_t           st;
  rd_sel_e           rdSel;
  logic [BYTE_W-1:0] ctrlReg;
  logic [BYTE_W-1:0] statReg;
  logic              irqPend;

  prn_port_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .ctrlReg(ctrlReg), .statReg(statReg),
    .st(st), .rdSel(rdSel)
  );

  prn_port_dp dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .rdSel(rdSel), .wrData(wrData),
    .inByte(inByte), .inLoad(inLoad), .rdData(rdData),
    .ctrlReg(ctrlReg), .statReg(statReg), .txValid(txValid),
    .txByte(txByte), .irqPend(irqPend)
  );

  assign irqOut = irqPend;

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !rdEn) |=> $stable(irqOut));
  p_both_noside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && wrEn && addr[DEC_W-1:0] == OFS_STAT) |=> ($stable(irqOut) && $stable(statReg)));
endmodule

// File: tb/prn_port_regs_tb_top.sv
module prn_port_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rdEn = 1'b0;
  logic              wrEn = 1'b0;
  logic [7:0]        wrData = '0;
  logic [7:0]        rdData;
  logic [7:0]        inByte = '0;
  logic              inLoad = 1'b0;
  logic              txValid;
  logic [7:0]        txByte;
  logic              irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] mOut, mIn, mStat, mCtrl;
  logic       mPend;

  always #(CLK_PERIOD/2) clk = ~clk;

  prn_port_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .inByte(inByte), .inLoad(inLoad),
    .txValid(txValid), .txByte(txByte), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    case (a[2:0])
      3'd0:    return mCtrl[5] ? mIn : mOut;
      3'd1:    return mStat;
      3'd2:    return mCtrl;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    case (a[2:0])
      3'd0:    return "R6 data read";
      3'd1:    return "R7 status read";
      3'd2:    return "R2 control read";
      default: return "R1 unmapped read";
    endcase
  endfunction

  task automatic access(input bit w, input bit r, input logic [7:0] a,
                        input logic [7:0] v, input string tag);
    logic       eTx;
    logic [7:0] eByte, nv;
    eTx = 1'b0; eByte = '0;
    @(negedge clk);
    addr = a; wrEn = w; rdEn = r; wrData = v;
    #1;
    if (r) chk(readTag(a), rdData, modelRead(a));
    if (w) begin
      if (a[2:0] == 3'd0) mOut = v;
      if (a[2:0] == 3'd2) begin
        nv = v | 8'hC0;
        if (!nv[2]) mStat = 8'hD8;
        else if (nv[3]) begin
          if (nv[0]) begin
            mStat[7] = 1'b0;
            if (!mCtrl[0]) begin eTx = 1'b1; eByte = mOut; end
          end else if (mCtrl[4]) mPend = 1'b1;
        end
        mCtrl = nv;
      end
    end else if (r && a[2:0] == 3'd1) begin
      mPend = 1'b0;
      if (!mStat[7] && !mCtrl[0]) begin
        if (mStat[6]) mStat[6] = 1'b0;
        else mStat[7:6] = 2'b11;
      end
    end
    @(posedge clk); #1;
    wrEn = 1'b0; rdEn = 1'b0;
    chk({"R4 txValid ", tag}, {7'd0, txValid}, {7'd0, eTx});
    if (eTx) chk({"R4 txByte ", tag}, txByte, eByte);
    chk({"R10 irqOut ", tag}, {7'd0, irqOut}, {7'd0, mPend});
  endtask

  task automatic loadIn(input logic [7:0] b);
    @(negedge clk);
    inByte = b; inLoad = 1'b1;
    @(posedge clk); #1;
    inLoad = 1'b0;
    mIn = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mOut = 8'hFF; mIn = 8'hFF; mStat = 8'hD9; mCtrl = 8'hCC; mPend = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset values through the ports
    chk("R9 irq at reset", {7'd0, irqOut}, 8'd0);
    access(0, 1, 8'h01, 0, "R9 reset status");
    access(0, 1, 8'h02, 0, "R9 reset control");
    access(0, 1, 8'h00, 0, "R9 reset out latch");
    // R1: unmapped offsets and aliasing of high address bits
    for (int k = 3; k < 8; k++) access(0, 1, 8'(k), 0, "R1 unmapped");
    access(0, 1, 8'hFA, 0, "R1 alias control");
    access(1, 0, 8'hF8, 8'h3C, "R1 alias data write");
    access(0, 1, 8'h00, 0, "R1 alias data read");
    // R6: direction selects the input latch
    loadIn(8'hA5);
    access(1, 0, 8'h02, 8'h2C, "R6 dir in");
    access(0, 1, 8'h00, 0, "R6 read input latch");
    // R3: init low forces status
    access(1, 0, 8'h02, 8'h00, "R3 init low");
    access(0, 1, 8'h01, 0, "R3 status after init");
    // R4: strobe edge sends, held strobe does not
    access(1, 0, 8'h00, 8'h5A, "R4 data");
    access(1, 0, 8'h02, 8'h0C, "R4 strobe low");
    access(1, 0, 8'h02, 8'h0D, "R4 strobe rise");
    access(1, 0, 8'h02, 8'h0D, "R4 strobe held");
    // R5: pending needs interrupt enable already stored
    access(1, 0, 8'h02, 8'h1C, "R5 enable first");
    access(1, 0, 8'h02, 8'h1C, "R5 pend set");
    // R11: combined access keeps side effects off
    access(1, 1, 8'h01, 8'h00, "R11 both");
    access(0, 1, 8'h01, 0, "R7 clear pend");
    // R8: ack/busy stepping over consecutive reads
    access(1, 0, 8'h02, 8'h0D, "R8 clear busy");
    access(1, 0, 8'h02, 8'h0C, "R8 strobe low");
    for (int k = 0; k < 4; k++) access(0, 1, 8'h01, 0, "R8 step");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] a, v;
      op = $urandom_range(0, 9);
      a = 8'($urandom);
      v = 8'($urandom);
      if (op < 3)      access(1, 0, {a[7:3], 3'd2}, v, "rand ctrl");
      else if (op < 5) access(0, 1, {a[7:3], 3'd1}, 0, "rand status");
      else if (op < 6) access(1, 0, a, v, "rand write");
      else if (op < 8) access(0, 1, a, 0, "rand read");
      else if (op < 9) access(1, 1, a, v, "R11 rand both");
      else             loadIn(v);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule